// File: doc/BRIEF.md
# Prescaled Timer/Counter with Watchdog Divider

This block holds an 8-bit up-counter and an instruction-cycle tick generator. The tick is built from the fast oscillator clock and is one oscillator cycle in two or one in four, chosen by a configuration input. The counter counts either those ticks or edges on an external pin. The pin is synchronized and sampled once per tick. An optional power-of-two prescaler can sit in front of the counter. When the counter wraps, a one-cycle overflow pulse is raised.

A second prescaler feeds an 8-bit watchdog count from the same tick, and that prescaler has its own ratio. When the watchdog count wraps, a one-cycle timeout pulse is raised. Either the watchdog-clear strobe or the sleep strobe restarts the watchdog count and its prescaler.

The processor core drives a small write port that has a 2-bit address. Address 0 loads the counter value. Any load of the counter also restarts the counter's prescaler. The other addresses set the mode fields and the watchdog ratio. All logic runs on the oscillator clock and uses the tick as an enable.

Top module: `tmr_cnt_top`

## Requirements
- R1: While reset is high, and in the cycle after it falls, `cnt_val` is 0 and both `ovf_pulse` and `wdt_timeout` are low. The control fields reset to 0, which selects internal source, prescaler off, rising edge and ratio code 0 for both prescalers.
- R2: With the internal source and the prescaler off, the counter advances by exactly one per tick. With `cyc_div4`=0 a tick comes every 2 clock cycles.
- R3: With `cyc_div4`=1 a tick comes every 4 clock cycles.
- R4: When the prescaler is on, ratio code k (0 to 7) divides the count source by 2^(k+1), so 000 gives /2 and 111 gives /256.
- R5: A write to address 0 loads `wr_data` into the counter on that clock edge and restarts the counter prescaler from zero.
- R6: When a write to address 0 and an increment fall on the same edge, the written value wins.
- R7: Control register (address 1): bit 4 set selects the external pin as source. Bit 5 selects the falling edge (1) or the rising edge (0). Bit 3 turns the prescaler on. Bits 2:0 hold the counter ratio code. In external mode only the chosen pin edge advances the count, and ticks alone do not.
- R8: A wrap from 0xFF to 0x00 raises `ovf_pulse` for one cycle, in the same cycle that `cnt_val` shows 0x00.
- R9: Address 2 bits 2:0 hold the watchdog ratio code k. After a clear, the watchdog times out after 256·2^(k+1) ticks with a one-cycle `wdt_timeout` pulse.
- R10: `wdt_clr` or `sleep_cmd` restarts the watchdog count and its prescaler, and no timeout follows in the next cycle.
- R11: A write to address 3 changes no state: the counter value and the mode are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_div4 | input | 1 | Tick is clock/4 when 1, clock/2 when 0 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 counter, 1 control, 2 watchdog ratio, 3 unused |
| wr_data | input | 8 | Write data |
| ext_pin | input | 1 | External count input, asynchronous |
| wdt_clr | input | 1 | Watchdog-clear strobe |
| sleep_cmd | input | 1 | Sleep strobe, also clears the watchdog |
| cnt_val | output | 8 | Current counter value |
| ovf_pulse | output | 1 | One-cycle counter wrap flag |
| wdt_timeout | output | 1 | One-cycle watchdog expiry pulse |

## Verification
The bound checker watches every cycle for the following properties. A counter load shows the written value on the next cycle. Without a load, the counter only holds or steps by one. Overflow coincides with a zero count and never lasts two cycles. A clear or sleep strobe is never followed directly by a timeout.

Rates and division ratios are only visible over many cycles, so the directed scenarios measure them. The same goes for edge polarity on the external pin, the prescaler restart caused by a counter write, the watchdog period, and the fact that an unused address has no effect.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int RATIO_W = 3;

  typedef enum logic [1:0] {
    SEL_COUNT = 2'd0,
    SEL_MODE  = 2'd1,
    SEL_WDOG  = 2'd2,
    SEL_SPARE = 2'd3
  } reg_sel_e;

  // mode register, bit 5 down to bit 0
  typedef struct packed {
    logic               fall_edge;
    logic               ext_src;
    logic               pre_on;
    logic [RATIO_W-1:0] ratio;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int DIV_W = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic div4,
  output logic tick
);
  logic [DIV_W-1:0] phase_q;
  logic [DIV_W-1:0] last_phase;

  assign last_phase = div4 ? {DIV_W{1'b1}} : {{(DIV_W-1){1'b0}}, 1'b1};
  assign tick       = (phase_q >= last_phase);

  always_ff @(posedge clk) begin
    if (rst)       phase_q <= '0;
    else if (tick) phase_q <= '0;
    else           phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic pin,
  input  logic fall_sel,
  output logic edge_ev
);
  logic [STAGES-1:0] shift_q;
  logic              prev_q;
  logic              now_lvl;
  logic              rise, fall;

  assign now_lvl = shift_q[STAGES-1];
  assign rise    = now_lvl & ~prev_q;
  assign fall    = ~now_lvl & prev_q;
  assign edge_ev = tick & (fall_sel ? fall : rise);

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q <= '0;
      prev_q  <= 1'b0;
    end else if (tick) begin
      shift_q <= {shift_q[STAGES-2:0], pin};
      prev_q  <= now_lvl;
    end
  end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int W     = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             ev,
  input  logic [SEL_W-1:0] sel,
  output logic             carry
);
  logic [W-1:0] acc_q;
  logic [W-1:0] mask;

  assign mask  = W'((32'd2 << sel) - 32'd1);
  assign carry = ev & ((acc_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || clr) acc_q <= '0;
    else if (ev)    acc_q <= acc_q + 1'b1;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      wrap <= 1'b0;
    end else begin
      wrap <= inc & (&cnt) & ~load & ~clr;
      if (clr)       cnt <= '0;
      else if (load) cnt <= load_val;
      else if (inc)  cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_cnt_top.sv
module tmr_cnt_top
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PRE_W       = 8,
  parameter int WDT_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_W       = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc_div4,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             ext_pin,
  input  logic             wdt_clr,
  input  logic             sleep_cmd,
  output logic [CNT_W-1:0] cnt_val,
  output logic             ovf_pulse,
  output logic             wdt_timeout
);
  mode_t              mode_q;
  logic [RATIO_W-1:0] wdog_ratio_q;
  logic               tick, pin_ev, src_ev, pre_carry, cnt_inc;
  logic               wr_count, wdog_kick, wdog_carry;
  logic [WDT_W-1:0]   wdog_cnt;

  assign wr_count  = wr_en && (reg_sel_e'(wr_addr) == SEL_COUNT);
  assign wdog_kick = wdt_clr | sleep_cmd;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q       <= '0;
      wdog_ratio_q <= '0;
    end else if (wr_en) begin
      case (reg_sel_e'(wr_addr))
        SEL_MODE: mode_q       <= mode_t'(wr_data[MODE_W-1:0]);
        SEL_WDOG: wdog_ratio_q <= wr_data[RATIO_W-1:0];
        default: ;
      endcase
    end
  end

  tmr_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .div4(cyc_div4), .tick(tick)
  );

  tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .tick(tick), .pin(ext_pin),
    .fall_sel(mode_q.fall_edge), .edge_ev(pin_ev)
  );

  assign src_ev  = mode_q.ext_src ? pin_ev : tick;
  assign cnt_inc = mode_q.pre_on ? pre_carry : src_ev;

  tmr_prescaler #(.W(PRE_W), .SEL_W(RATIO_W)) u_cnt_pre (
    .clk(clk), .rst(rst), .clr(wr_count), .ev(src_ev),
    .sel(mode_q.ratio), .carry(pre_carry)
  );

  tmr_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(1'b0), .load(wr_count), .load_val(wr_data),
    .inc(cnt_inc), .cnt(cnt_val), .wrap(ovf_pulse)
  );

  tmr_prescaler #(.W(PRE_W), .SEL_W(RATIO_W)) u_wdog_pre (
    .clk(clk), .rst(rst), .clr(wdog_kick), .ev(tick),
    .sel(wdog_ratio_q), .carry(wdog_carry)
  );

  tmr_counter #(.W(WDT_W)) u_wdog (
    .clk(clk), .rst(rst), .clr(wdog_kick), .load(1'b0), .load_val('0),
    .inc(wdog_carry), .cnt(wdog_cnt), .wrap(wdt_timeout)
  );

  logic unused_wdog;
  assign unused_wdog = ^wdog_cnt;
endmodule

// File: rtl/tmr_cnt_chk.sv
module tmr_cnt_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [CNT_W-1:0] wr_data,
  input logic             wdt_clr,
  input logic             sleep_cmd,
  input logic [CNT_W-1:0] cnt_val,
  input logic             ovf_pulse,
  input logic             wdt_timeout
);
  p_load_wins_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 2'd0) |=> (cnt_val == $past(wr_data)));

  // R6: a load on the same edge as an increment still shows the written value
  p_load_over_inc_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 2'd0) |=> (cnt_val != $past(wr_data) + 1'b1));

  p_step_by_one_r2: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_addr == 2'd0) |=>
      (cnt_val == $past(cnt_val) || cnt_val == $past(cnt_val) + 1'b1));

  p_ovf_at_zero_r8: assert property (@(posedge clk) disable iff (rst)
    ovf_pulse |-> (cnt_val == '0));

  p_ovf_single_r8: assert property (@(posedge clk) disable iff (rst)
    ovf_pulse |=> !ovf_pulse);

  p_kick_no_timeout_r10: assert property (@(posedge clk) disable iff (rst)
    (wdt_clr || sleep_cmd) |=> !wdt_timeout);

  p_timeout_single_r9: assert property (@(posedge clk) disable iff (rst)
    wdt_timeout |=> !wdt_timeout);
endmodule

bind tmr_cnt_top tmr_cnt_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/test_tmr_cnt_top.sv
module test_tmr_cnt_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  MAX_CYCLES = 200000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cyc_div4 = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       ext_pin = 1'b0;
  logic       wdt_clr = 1'b0;
  logic       sleep_cmd = 1'b0;
  logic [7:0] cnt_val;
  logic       ovf_pulse;
  logic       wdt_timeout;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_cnt_top i_tmr_cnt_top (
    .clk(clk), .rst(rst), .cyc_div4(cyc_div4), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .ext_pin(ext_pin),
    .wdt_clr(wdt_clr), .sleep_cmd(sleep_cmd), .cnt_val(cnt_val),
    .ovf_pulse(ovf_pulse), .wdt_timeout(wdt_timeout)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_in2(input string req, input int act, input int e0, input int e1);
    n_checks++;
    if (act != e0 && act != e1) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d or %0d", req, act, e0, e1);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rate_window(input int clocks, input int exp, input string req);
    logic [7:0] c0;
    @(negedge clk);
    c0 = cnt_val;
    idle(clocks);
    check(req, int'(8'(cnt_val - c0)), exp);
  endtask

  task automatic measure_wdt(input int limit, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!wdt_timeout && n < limit);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    idle(4);
    check("R1 cnt during reset", cnt_val, 0);
    rst = 1'b0;
    check("R1 cnt after reset", cnt_val, 0);
    check("R1 ovf after reset", ovf_pulse, 0);
    check("R1 timeout after reset", wdt_timeout, 0);
  endtask

  task automatic t_internal_div2();
    reg_write(2'd1, 8'h00);
    rate_window(40, 20, "R2 internal /2 rate");
  endtask

  task automatic t_div4();
    cyc_div4 = 1'b1;
    idle(8);
    rate_window(40, 10, "R3 internal /4 rate");
    cyc_div4 = 1'b0;
    idle(8);
  endtask

  task automatic t_ratio();
    reg_write(2'd1, 8'h08);
    rate_window(40, 10, "R4 ratio code 0");
    reg_write(2'd1, 8'h0A);
    rate_window(160, 10, "R4 ratio code 2");
    reg_write(2'd1, 8'h0B);
    rate_window(320, 10, "R4 ratio code 3");
  endtask

  task automatic t_pre_clear();
    reg_write(2'd1, 8'h0F);
    idle(300);
    reg_write(2'd0, 8'h10);
    check("R5 load value", cnt_val, 8'h10);
    idle(500);
    check("R5 prescaler restarted, no step yet", cnt_val, 8'h10);
    idle(40);
    check("R5 first step after full ratio", cnt_val, 8'h11);
  endtask

  task automatic t_write_prio();
    reg_write(2'd1, 8'h00);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h55;
    idle(2);
    wr_en = 1'b0;
    check("R6 write beats increment", cnt_val, 8'h55);
    idle(2);
    check("R6 counting resumes", cnt_val, 8'h56);
  endtask

  task automatic t_overflow();
    int seen = 0;
    int bad_zero = 0;
    reg_write(2'd0, 8'hFE);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (ovf_pulse) begin
        seen++;
        if (cnt_val != 8'h00) bad_zero++;
      end
    end
    check("R8 one overflow cycle", seen, 1);
    check("R8 count zero with overflow", bad_zero, 0);
  endtask

  task automatic t_external();
    ext_pin = 1'b0;
    reg_write(2'd1, 8'h10);
    idle(20);
    reg_write(2'd0, 8'h00);
    ext_pin = 1'b1; idle(12);
    ext_pin = 1'b0; idle(12);
    ext_pin = 1'b1; idle(12);
    ext_pin = 1'b0; idle(12);
    ext_pin = 1'b1; idle(20);
    check("R7 rising edges counted", cnt_val, 3);
    reg_write(2'd1, 8'h30);
    idle(20);
    reg_write(2'd0, 8'h00);
    ext_pin = 1'b0; idle(12);
    ext_pin = 1'b1; idle(12);
    ext_pin = 1'b0; idle(20);
    check("R7 falling edges counted", cnt_val, 2);
    reg_write(2'd3, 8'hAA);
    idle(40);
    check("R11 spare address leaves count and mode", cnt_val, 2);
    reg_write(2'd1, 8'h00);
  endtask

  task automatic t_wdt();
    int n;
    reg_write(2'd2, 8'h00);
    @(negedge clk) wdt_clr = 1'b1;
    @(negedge clk) wdt_clr = 1'b0;
    measure_wdt(3000, n);
    check_in2("R9 timeout period code 0", n, 1023, 1024);
    @(negedge clk);
    check("R9 timeout lasts one cycle", wdt_timeout, 0);
    reg_write(2'd2, 8'h01);
    @(negedge clk) wdt_clr = 1'b1;
    @(negedge clk) wdt_clr = 1'b0;
    measure_wdt(5000, n);
    check_in2("R9 timeout period code 1", n, 2047, 2048);
  endtask

  task automatic t_sleep();
    int n;
    int early = 0;
    reg_write(2'd2, 8'h00);
    @(negedge clk) wdt_clr = 1'b1;
    @(negedge clk) wdt_clr = 1'b0;
    for (int i = 0; i < 800; i++) begin
      @(negedge clk);
      if (wdt_timeout) early++;
    end
    check("R10 no timeout before period", early, 0);
    @(negedge clk) sleep_cmd = 1'b1;
    @(negedge clk) sleep_cmd = 1'b0;
    measure_wdt(3000, n);
    check_in2("R10 sleep restarts watchdog", n, 1023, 1024);
  endtask

  initial begin
    t_reset();
    t_internal_div2();
    t_div4();
    t_ratio();
    t_pre_clear();
    t_write_prio();
    t_overflow();
    t_external();
    t_wdt();
    t_sleep();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule